// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the management-bus master that one network port uses to reach the registers of an external PHY. Software programs three words (a configuration word, an address word and a data word) over a small word-addressed register interface. Writing a fourth word, the operation word, starts one serial frame on the management clock and data lines. The block makes the management clock from the system clock through a programmable divider. It drives the data line through separate output and output-enable pins and samples it through an input pin. While a frame is in flight, a busy flag in the operation word reads as 1.

Two framing styles are offered. A start-of-frame selector in the configuration word chooses between them. In direct framing, a 2-bit opcode asks for a register write or a register read. In indirect framing, the opcode is put on the wire as it is and selects an address, write, read or read-with-increment cycle. An optional 32-bit preamble can be turned off. The sampled input can be inverted. The register address can step by one after each direct access, so that a block of registers can be walked.

Top module: `mdioMaster`

## Requirements
- R1: After reset, all four words read back as zero, and `mdc` and `mdioOe` are low.
- R2: The four words sit at word index 0 to 3 (`busAddr`). Configuration, index 0: bit0 enable, bit1 input invert, bit2 preamble on, bits4:3 frame selector, bits12:5 divider. Address, index 1: bits4:0 register, bits9:5 PHY. Data, index 2: bits15:0. Operation, index 3: bits1:0 opcode, bit2 auto-increment, bit31 busy, read-only. All writable fields read back what was written.
- R3: Busy reads 1 from the cycle after an accepted operation write. It stays 1 for exactly (32 + preamble bits) x 2 x (divider + 1) clocks, then clears.
- R4: `mdc` idles low. Each half period lasts divider + 1 system clocks.
- R5: A direct frame (selector 01) carries, MSB first: start bits 01, opcode 01 for a write or 10 for a read, 5-bit PHY address, 5-bit register address, turnaround, 16 data bits. On a write the turnaround is 10 and the data comes from the data word. `mdioOut` changes only while `mdc` is low.
- R6: On a read frame `mdioOe` is high for the first 14 bits and low for turnaround and data. The 16 bits sampled on the rising `mdc` edges, MSB first, land in the data word when the frame ends.
- R7: With selector 00 the start bits are 00 and the opcode goes onto the wire unchanged. Opcodes 0 and 1 drive the whole frame. Opcodes 2 and 3 are reads as in R6.
- R8: With preamble on, 32 bits of 1 with `mdioOe` high come before the start bits.
- R9: With invert on, each sampled input bit is complemented before capture.
- R10: An operation write while busy is ignored. The opcode readback and the frame in flight are unchanged.
- R11: With auto-increment set, the register address field steps by one, modulo 32, when a direct frame ends. The PHY field is kept. Indirect frames never change the address word.
- R12: With enable clear, an accepted operation sets busy for exactly one cycle. `mdc` does not toggle, `mdioOe` stays low, and the data word is unchanged.
- R13: In direct framing, opcodes 0 and 3 are ignored and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Word index of the register accessed |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data of the word selected by busAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data, driven value |
| mdioOe | output | 1 | Management data, output enable |
| mdioIn | input | 1 | Management data, sampled value |

## Verification
The bench builds the block with its default parameters: an 8-bit divider field, a 32-bit preamble, 5-bit address fields and 16-bit data. With these defaults a full preamble frame is a few hundred clocks. It runs each frame with a divider of 0, 1 or 2, so that bit timing, preamble, both framing styles and read capture all fit in short runs. A bench responder drives `mdioIn` after each falling `mdc` edge. This makes the read values and the inversion observable at the data word.

// File: rtl/mdioPkg.sv
package mdioPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic shift;   // advance to the next frame bit
    logic sample;  // capture one read data bit
    logic finish;  // frame complete
    logic inPre;   // preamble phase active
  } mdioStb_t;
endpackage

// File: rtl/mdioSeq.sv
module mdioSeq
  import mdioPkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_BITS = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             noopReq,
  input  logic             preEn,
  input  logic [DIV_W-1:0] div,
  input  logic             isRead,
  output mdioStb_t         stb,
  output logic             mdc,
  output logic             mdioOe,
  output logic             busy
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int PRE_W = $clog2(PRE_BITS);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] TA_IDX   = BIT_W'(FRAME_W - DATA_W - 2);
  localparam logic [BIT_W-1:0] DAT_IDX  = BIT_W'(FRAME_W - DATA_W);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_FRM, S_NOOP} seqState_t;
  seqState_t state;
  logic [DIV_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic [PRE_W-1:0] preCnt;
  logic mdcQ, running, tick, riseE, fallE;

  assign running = (state == S_PRE) || (state == S_FRM);
  assign tick    = running && (cnt >= div);
  assign riseE   = tick && !mdcQ;
  assign fallE   = tick && mdcQ;

  assign stb.inPre  = (state == S_PRE);
  assign stb.shift  = fallE && (state == S_FRM) && (bitCnt != LAST_IDX);
  assign stb.finish = fallE && (state == S_FRM) && (bitCnt == LAST_IDX);
  assign stb.sample = riseE && (state == S_FRM) && isRead && (bitCnt >= DAT_IDX);

  assign mdc    = mdcQ;
  assign busy   = (state != S_IDLE);
  assign mdioOe = (state == S_PRE) ||
                  ((state == S_FRM) && !(isRead && (bitCnt >= TA_IDX)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      mdcQ   <= 1'b0;
      bitCnt <= '0;
      preCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt    <= '0;
          mdcQ   <= 1'b0;
          bitCnt <= '0;
          preCnt <= '0;
          if (startReq)     state <= preEn ? S_PRE : S_FRM;
          else if (noopReq) state <= S_NOOP;
        end
        S_NOOP: state <= S_IDLE;
        default: begin
          if (tick) begin
            cnt  <= '0;
            mdcQ <= !mdcQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (fallE) begin
            if (state == S_PRE) begin
              if (preCnt == PRE_LAST) state <= S_FRM;
              else preCnt <= preCnt + 1'b1;
            end else if (bitCnt == LAST_IDX) begin
              state <= S_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R3: busy follows an accepted start on the next cycle
  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy);
  // R3: busy drops right after the last bit
  p_finish_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !busy);
  // R4: frame steps only on opposite clock edges
  p_edge_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shift | stb.finish, stb.sample}));
  // R12: idle line is quiet
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc));
  // R12: a disabled operation is a single busy cycle
  p_noop_short_r12: assert property (@(posedge clk) disable iff (!rstN)
    noopReq && !busy |=> busy ##1 !busy);
endmodule

// File: rtl/mdioRegs.sv
module mdioRegs
  import mdioPkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int FRAME_W = 6 + 2*ADDR_W + DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData,
  input  mdioStb_t         stb,
  input  logic             busy,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             startReq,
  output logic             noopReq,
  output logic             preEn,
  output logic [DIV_W-1:0] div,
  output logic             isRead
);
  localparam int CFG_W = 5 + DIV_W;

  logic [CFG_W-1:0]  cfgReg;
  logic [ADDR_W-1:0] phyAddr, regAddr;
  logic [DATA_W-1:0] dataReg, capReg;
  logic [1:0]        opReg;
  logic              autoInc, curDirect, curRead;
  logic [FRAME_W-1:0] shiftReg;
  logic enable, invertIn, indirect, opWr, legal;
  logic [1:0] wrOp, wireOp, startBits;
  logic unusedWrBits;

  assign unusedWrBits = ^busWrData[31:CFG_W];
  assign enable   = cfgReg[0];
  assign invertIn = cfgReg[1];
  assign preEn    = cfgReg[2];
  assign indirect = (cfgReg[4:3] == 2'b00);
  assign div      = cfgReg[5 +: DIV_W];

  assign wrOp      = busWrData[1:0];
  assign opWr      = busWr && (busAddr == 2'd3) && !busy;
  assign legal     = indirect || (wrOp == 2'd1) || (wrOp == 2'd2);
  assign startReq  = opWr && legal && enable;
  assign noopReq   = opWr && legal && !enable;
  assign wireOp    = indirect ? wrOp : ((wrOp == 2'd1) ? 2'b01 : 2'b10);
  assign startBits = indirect ? 2'b00 : 2'b01;
  assign isRead    = curRead;
  assign mdioOut   = stb.inPre ? 1'b1 : shiftReg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= '0;
      phyAddr   <= '0;
      regAddr   <= '0;
      dataReg   <= '0;
      capReg    <= '0;
      opReg     <= '0;
      autoInc   <= 1'b0;
      curDirect <= 1'b0;
      curRead   <= 1'b0;
      shiftReg  <= '0;
    end else begin
      if (busWr && busAddr == 2'd0) cfgReg <= busWrData[CFG_W-1:0];
      if (busWr && busAddr == 2'd1) {phyAddr, regAddr} <= busWrData[2*ADDR_W-1:0];
      if (busWr && busAddr == 2'd2) dataReg <= busWrData[DATA_W-1:0];
      if (opWr && legal) begin
        opReg     <= wrOp;
        autoInc   <= busWrData[2];
        curDirect <= !indirect;
        curRead   <= indirect ? wrOp[1] : (wrOp == 2'd2);
      end
      if (startReq)
        shiftReg <= {startBits, wireOp, phyAddr, regAddr, 2'b10, dataReg};
      else if (stb.shift)
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      if (stb.sample)
        capReg <= {capReg[DATA_W-2:0], mdioIn ^ invertIn};
      if (stb.finish) begin
        if (curRead) dataReg <= capReg;
        if (curDirect && autoInc) regAddr <= regAddr + 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      2'd0: busRdData[CFG_W-1:0] = cfgReg;
      2'd1: busRdData[2*ADDR_W-1:0] = {phyAddr, regAddr};
      2'd2: busRdData[DATA_W-1:0] = dataReg;
      default: begin
        busRdData[31]  = busy;
        busRdData[2]   = autoInc;
        busRdData[1:0] = opReg;
      end
    endcase
  end

  // R10: the latched operation holds while a frame runs
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(opReg));
  // R11: indirect frames leave the register address alone
  p_no_inc_indirect_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish && !curDirect && !(busWr && busAddr == 2'd1) |=> $stable(regAddr));
endmodule

// File: rtl/mdioMaster.sv
module mdioMaster
  import mdioPkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int FRAME_W = 6 + 2*ADDR_W + DATA_W;

  mdioStb_t stb;
  logic startReq, noopReq, preEn, isRead, busy;
  logic [DIV_W-1:0] div;

  mdioRegs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .stb(stb), .busy(busy),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .startReq(startReq), .noopReq(noopReq),
    .preEn(preEn), .div(div), .isRead(isRead)
  );

  mdioSeq #(.DIV_W(DIV_W), .PRE_BITS(PRE_BITS), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .noopReq(noopReq),
    .preEn(preEn), .div(div), .isRead(isRead), .stb(stb),
    .mdc(mdc), .mdioOe(mdioOe), .busy(busy)
  );

  // R5: data changes only while the clock is low
  p_out_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> $stable(mdioOut));
endmodule

// File: tb/tb_mdioMaster.sv
`timescale 1ns/1ps
module tb_mdioMaster;
  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, mdioIn = 1'b1;
  logic [1:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic mdc, mdioOut, mdioOe;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // frame observation
  logic [95:0] seenOut, seenOe;
  int rc, busyCyc, hiMin, hiMax, firstBusy;
  bit anyOe;

  mdioMaster dut (.clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  // start an operation and watch the line until busy drops
  task automatic doOp(input logic [31:0] opw, input int pre, input logic [15:0] pat, input logic inv);
    int hiRun = 0;
    logic prev = 1'b0;
    rc = 0; busyCyc = 0; hiMin = 9999; hiMax = 0; anyOe = 0;
    seenOut = '0; seenOe = '0; mdioIn = 1'b1;
    busWrite(2'd3, opw);
    firstBusy = busRdData[31];
    busAddr = 2'd3; #1;
    firstBusy = busRdData[31];
    while (busRdData[31] === 1'b1 && busyCyc < 5000) begin
      busyCyc++;
      if (mdioOe) anyOe = 1;
      if (mdc && !prev) begin seenOut[rc] = mdioOut; seenOe[rc] = mdioOe; rc++; end
      if (!mdc && prev) begin
        if (hiRun < hiMin) hiMin = hiRun;
        if (hiRun > hiMax) hiMax = hiRun;
        hiRun = 0;
        if (rc >= pre + 16 && rc < pre + 32) mdioIn = pat[pre + 31 - rc] ^ inv;
        else mdioIn = 1'b1;
      end
      if (mdc) hiRun++;
      prev = mdc;
      @(negedge clk); #1;
    end
  endtask

  function automatic logic [31:0] frameOut(input int pre);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = seenOut[pre+i];
    return w;
  endfunction
  function automatic logic [31:0] frameOe(input int pre);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = seenOe[pre+i];
    return w;
  endfunction

  task automatic tReset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin busRead(2'(a), d); chk("R1 reg", d, 0); end
    chk("R1 mdc/oe", {mdc, mdioOe}, 0);
  endtask

  task automatic tRegs();
    logic [31:0] d;
    busWrite(2'd0, 32'h0000_1FFE); busRead(2'd0, d); chk("R2 cfg", d, 32'h1FFE);
    busWrite(2'd1, 32'hFFFF_F3FF); busRead(2'd1, d); chk("R2 addr", d, 32'h3FF);
    busWrite(2'd2, 32'h1234_BEEF); busRead(2'd2, d); chk("R2 data", d, 32'hBEEF);
    busWrite(2'd0, 32'h0);
  endtask

  task automatic tDirectWrite();
    logic [31:0] d;
    busWrite(2'd0, 32'h9);                 // enable, selector 01, div 0
    busWrite(2'd1, (5 << 5) | 32'h12);
    busWrite(2'd2, 32'hA5C3);
    doOp(32'h1, 0, 16'h0, 1'b0);
    chk("R3 busy next cycle", firstBusy, 1);
    chk("R3 busy length", busyCyc, 64);
    chk("R4 high phase div0", {hiMin[7:0], hiMax[7:0]}, {8'd1, 8'd1});
    chk("R5 write frame", frameOut(0), {2'b01, 2'b01, 5'd5, 5'h12, 2'b10, 16'hA5C3});
    chk("R5 oe all frame", frameOe(0), 32'hFFFF_FFFF);
    busRead(2'd1, d); chk("R11 no inc without flag", d, (5 << 5) | 32'h12);
  endtask

  task automatic tDirectRead();
    logic [31:0] d;
    busWrite(2'd0, 32'h1 | 32'h2 | (1 << 3) | (2 << 5)); // invert, div 2
    busWrite(2'd1, (5 << 5) | 32'h12);
    doOp(32'h2 | 32'h4, 0, 16'h3C96, 1'b1);
    chk("R3 busy length div2", busyCyc, 192);
    chk("R4 high phase div2", {hiMin[7:0], hiMax[7:0]}, {8'd3, 8'd3});
    chk("R6 read header", frameOut(0) & 32'hFFFC_0000, {2'b01, 2'b10, 5'd5, 5'h12, 18'h0});
    chk("R6 oe release", frameOe(0), 32'hFFFC_0000);
    busRead(2'd2, d); chk("R9 inverted capture", d, 32'h3C96);
    busRead(2'd1, d); chk("R11 increment", d, (5 << 5) | 32'h13);
    // wrap from 31 to 0
    busWrite(2'd0, 32'h9);
    busWrite(2'd1, (7 << 5) | 32'h1F);
    doOp(32'h1 | 32'h4, 0, 16'h0, 1'b0);
    busRead(2'd1, d); chk("R11 wrap", d, (7 << 5));
  endtask

  task automatic tPreamble();
    logic [31:0] d;
    busWrite(2'd0, 32'h1 | 32'h4 | (1 << 3) | (1 << 5)); // preamble, div 1
    busWrite(2'd1, (3 << 5) | 32'h4);
    doOp(32'h2, 32, 16'h8001, 1'b0);
    chk("R3 busy with preamble", busyCyc, 256);
    chk("R8 preamble ones", {seenOut[31:0], seenOe[31:0]}, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 header after preamble", frameOut(32) & 32'hFFFC_0000, {2'b01, 2'b10, 5'd3, 5'h4, 18'h0});
    busRead(2'd2, d); chk("R6 read capture", d, 32'h8001);
  endtask

  task automatic tIndirect();
    logic [31:0] d;
    busWrite(2'd0, 32'h1);                 // enable, selector 00, div 0
    busWrite(2'd1, (9 << 5) | 32'h3);
    busWrite(2'd2, 32'h0F0F);
    doOp(32'h0, 0, 16'h0, 1'b0);
    chk("R7 address frame", frameOut(0), {2'b00, 2'b00, 5'd9, 5'h3, 2'b10, 16'h0F0F});
    chk("R7 address frame oe", frameOe(0), 32'hFFFF_FFFF);
    doOp(32'h3, 0, 16'h5A6B, 1'b0);
    chk("R7 read frame", frameOut(0) & 32'hFFFC_0000, {2'b00, 2'b11, 5'd9, 5'h3, 18'h0});
    chk("R7 read release", frameOe(0), 32'hFFFC_0000);
    busRead(2'd2, d); chk("R7 read data", d, 32'h5A6B);
    doOp(32'h2 | 32'h4, 0, 16'hC001, 1'b0);
    chk("R7 post-inc read opcode", frameOut(0) & 32'hF000_0000, 32'h2000_0000);
    busRead(2'd1, d); chk("R11 indirect keeps address", d, (9 << 5) | 32'h3);
  endtask

  task automatic tBusyIgnore();
    logic [31:0] d;
    busWrite(2'd0, 32'h9);
    busWrite(2'd2, 32'h7777);
    busWrite(2'd3, 32'h1);
    busWrite(2'd3, 32'h2);                 // during busy: ignored
    busRead(2'd3, d); chk("R10 opcode kept", d, 32'h8000_0001);
    repeat (80) @(negedge clk);
    busRead(2'd3, d); chk("R10 no second frame", d[31], 0);
    busRead(2'd2, d); chk("R10 data not read over", d, 32'h7777);
  endtask

  task automatic tDisabled();
    logic [31:0] d;
    busWrite(2'd0, 32'h8);                 // selector 01, enable clear
    busWrite(2'd2, 32'h4321);
    doOp(32'h2, 0, 16'h0, 1'b0);
    chk("R12 busy one cycle", {firstBusy[7:0], busyCyc[7:0]}, {8'd1, 8'd1});
    chk("R12 no mdc, no oe", {rc[7:0], 7'd0, anyOe}, 16'h0);
    busRead(2'd2, d); chk("R12 data unchanged", d, 32'h4321);
  endtask

  task automatic tIllegal();
    busWrite(2'd0, 32'h9);
    doOp(32'h0, 0, 16'h0, 1'b0);
    chk("R13 direct opcode 0 ignored", busyCyc, 0);
    doOp(32'h3, 0, 16'h0, 1'b0);
    chk("R13 direct opcode 3 ignored", busyCyc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tDirectWrite();
    tDirectRead();
    tPreamble();
    tIndirect();
    tBusyIgnore();
    tDisabled();
    tIllegal();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule